// File: doc/BRIEF.md
# GPIO Port with Per-Pin Function Mux

This block is one 16-pin general-purpose I/O port. Each pin is either under GPIO control or handed to one of four peripheral functions. Software sees a small register bus with these registers:
- an output data latch;
- a direction register;
- an input-enable register;
- a function-enable register;
- a packed selector register holding two bits per pin.

Data and direction also have write-one-to-set and write-one-to-clear aliases. These change single bits without a read-modify-write sequence.

Pad inputs pass through a two-stage synchronizer. The synchronized values go to an interrupt block, and the data read returns them for pins whose input sensing is enabled. In GPIO mode the pad is driven from the output latch and the direction register. In function mode the pad's output and output-enable come from the peripheral chosen by that pin's selector field.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset every register reads 0, pad_oe is 0 and sync_in is 0. Every pin therefore starts as a GPIO input with sensing disabled.
- R2: Address 0 written replaces the whole output latch. At address 1, each 1 in wdata sets that latch bit and leaves the other bits unchanged. Reads at addresses 1 and 2 return the latch.
- R3: At address 2, each 1 in wdata clears that latch bit and leaves the other bits unchanged.
- R4: Address 3 writes the whole direction register (1 = output). Addresses 4 and 5 set or clear the written-1 bits only. Reads at addresses 3, 4 and 5 return the direction register.
- R5: A read at address 0 gives each pin its synchronized pad value where input-enable (address 6) is 1, and its output-latch bit where input-enable is 0.
- R6: Where function-enable (address 7) is 0, pad_oe[n] equals direction[n] and pad_out[n] equals latch[n].
- R7: Where function-enable is 1, pad_out[n] = fn_out[f*16+n] and pad_oe[n] = fn_oe[f*16+n]. Here f is the selector at address 8, bits 2n+1:2n.
- R8: sync_in equals pad_in as it was two clock edges earlier, whatever the input-enable setting.
- R9: A write to an address above 8 changes no register, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | 16 | Raw pad input values |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| fn_out | input | 64 | Peripheral outputs, function f of pin n at bit f*16+n |
| fn_oe | input | 64 | Peripheral output enables, same layout |
| sync_in | output | 16 | Synchronized pad inputs for the interrupt block |

## Verification
The bench uses the default build of 16 pins, four functions and two synchronizer stages. This small configuration makes a full sweep affordable: every pin is tried with every selector value. The sweep covers rotating per-pin selector patterns, several peripheral data patterns, and mixed function-enable masks. It also covers the set/clear alias arithmetic, the input-enable blend of the data read, and the two-edge synchronizer latency.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_DATA   = 4'd0,
    RA_DSET   = 4'd1,
    RA_DCLR   = 4'd2,
    RA_DIR    = 4'd3,
    RA_DIRSET = 4'd4,
    RA_DIRCLR = 4'd5,
    RA_INEN   = 4'd6,
    RA_FEN    = 4'd7,
    RA_FSEL   = 4'd8
  } reg_addr_t;

  localparam logic [ADDR_W-1:0] LAST_ADDR = 4'd8;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mux_regs.sv
module gpio_mux_regs
  import gpio_mux_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int SELW = 2,
  localparam int MUXW = NPIN * SELW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [MUXW-1:0]   wdata,
  input  logic [NPIN-1:0]   in_sync,
  output logic [NPIN-1:0]   dout_q,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   inen_q,
  output logic [NPIN-1:0]   fen_q,
  output logic [MUXW-1:0]   fsel_q,
  output logic [MUXW-1:0]   rdata
);
  function automatic logic [NPIN-1:0] set_bits(logic [NPIN-1:0] cur, logic [NPIN-1:0] m);
    return cur | m;
  endfunction

  function automatic logic [NPIN-1:0] clr_bits(logic [NPIN-1:0] cur, logic [NPIN-1:0] m);
    return cur & ~m;
  endfunction

  function automatic logic [NPIN-1:0] blend_read(logic [NPIN-1:0] pin_v, logic [NPIN-1:0] latch,
                                                 logic [NPIN-1:0] en);
    return (pin_v & en) | (latch & ~en);
  endfunction

  logic [NPIN-1:0] wmask;
  reg_addr_t       ra;

  assign wmask = wdata[NPIN-1:0];
  assign ra    = reg_addr_t'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      inen_q <= '0;
      fen_q  <= '0;
      fsel_q <= '0;
    end else if (wr) begin
      case (ra)
        RA_DATA:   dout_q <= wmask;
        RA_DSET:   dout_q <= set_bits(dout_q, wmask);
        RA_DCLR:   dout_q <= clr_bits(dout_q, wmask);
        RA_DIR:    dir_q  <= wmask;
        RA_DIRSET: dir_q  <= set_bits(dir_q, wmask);
        RA_DIRCLR: dir_q  <= clr_bits(dir_q, wmask);
        RA_INEN:   inen_q <= wmask;
        RA_FEN:    fen_q  <= wmask;
        RA_FSEL:   fsel_q <= wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (ra)
      RA_DATA:                       rdata[NPIN-1:0] = blend_read(in_sync, dout_q, inen_q);
      RA_DSET, RA_DCLR:              rdata[NPIN-1:0] = dout_q;
      RA_DIR, RA_DIRSET, RA_DIRCLR:  rdata[NPIN-1:0] = dir_q;
      RA_INEN:                       rdata[NPIN-1:0] = inen_q;
      RA_FEN:                        rdata[NPIN-1:0] = fen_q;
      RA_FSEL:                       rdata           = fsel_q;
      default:                       rdata           = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pin_sel.sv
module gpio_pin_sel #(
  parameter int NFUNC = 4,
  parameter int SELW  = 2
) (
  input  logic             fen,
  input  logic [SELW-1:0]  sel,
  input  logic             gpio_out,
  input  logic             gpio_oe,
  input  logic [NFUNC-1:0] fo,
  input  logic [NFUNC-1:0] foe,
  output logic             pad_out,
  output logic             pad_oe
);
  logic per_out, per_oe;

  always_comb begin
    per_out = 1'b0;
    per_oe  = 1'b0;
    for (int f = 0; f < NFUNC; f++) begin
      if (sel == SELW'(f)) begin
        per_out = fo[f];
        per_oe  = foe[f];
      end
    end
  end

  assign pad_out = fen ? per_out : gpio_out;
  assign pad_oe  = fen ? per_oe  : gpio_oe;
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int NPIN   = 16,
  parameter int NFUNC  = 4,
  parameter int STAGES = 2,
  localparam int SELW  = (NFUNC > 1) ? $clog2(NFUNC) : 1,
  localparam int MUXW  = NPIN * SELW,
  localparam int FW    = NPIN * NFUNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [MUXW-1:0]   bus_wdata,
  output logic [MUXW-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  input  logic [FW-1:0]     fn_out,
  input  logic [FW-1:0]     fn_oe,
  output logic [NPIN-1:0]   sync_in
);
  logic [NPIN-1:0] dout_q, dir_q, inen_q, fen_q;
  logic [MUXW-1:0] fsel_q;

  gpio_in_sync #(.WIDTH(NPIN), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_in)
  );

  gpio_mux_regs #(.NPIN(NPIN), .SELW(SELW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .in_sync(sync_in), .dout_q(dout_q), .dir_q(dir_q), .inen_q(inen_q),
    .fen_q(fen_q), .fsel_q(fsel_q), .rdata(bus_rdata)
  );

  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    logic [NFUNC-1:0] fo_v, foe_v;
    for (genvar f = 0; f < NFUNC; f++) begin : g_fn
      assign fo_v[f]  = fn_out[f*NPIN+n];
      assign foe_v[f] = fn_oe[f*NPIN+n];
    end
    gpio_pin_sel #(.NFUNC(NFUNC), .SELW(SELW)) u_sel (
      .fen(fen_q[n]), .sel(fsel_q[n*SELW +: SELW]),
      .gpio_out(dout_q[n]), .gpio_oe(dir_q[n]),
      .fo(fo_v), .foe(foe_v),
      .pad_out(pad_out[n]), .pad_oe(pad_oe[n])
    );
  end
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk
  import gpio_mux_pkg::*;
#(
  parameter int NPIN   = 16,
  parameter int SELW   = 2,
  parameter int STAGES = 2,
  localparam int MUXW  = NPIN * SELW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [MUXW-1:0]   bus_wdata,
  input logic [NPIN-1:0]   pad_in,
  input logic [NPIN-1:0]   sync_in,
  input logic [NPIN-1:0]   pad_out,
  input logic [NPIN-1:0]   pad_oe,
  input logic [NPIN-1:0]   dout_q,
  input logic [NPIN-1:0]   dir_q,
  input logic [NPIN-1:0]   inen_q,
  input logic [NPIN-1:0]   fen_q,
  input logic [MUXW-1:0]   fsel_q
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_DATA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_DSET) |=> (dout_q == ($past(dout_q) | $past(bus_wdata[NPIN-1:0])))); // R2

  AST_DATA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_DCLR) |=> (dout_q == ($past(dout_q) & ~$past(bus_wdata[NPIN-1:0])))); // R3

  AST_DIR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_DIRSET) |=> (dir_q == ($past(dir_q) | $past(bus_wdata[NPIN-1:0])))); // R4

  AST_GPIO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe ^ dir_q) | (pad_out ^ dout_q)) & ~fen_q) == '0); // R6

  AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr > LAST_ADDR) |=>
      ($stable(dout_q) && $stable(dir_q) && $stable(inen_q) && $stable(fen_q) && $stable(fsel_q))); // R9

  if (STAGES == 2) begin : g_sync2
    AST_SYNC_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> (sync_in == $past(pad_in, 2))); // R8
  end
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.NPIN(NPIN), .SELW(SELW), .STAGES(STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .pad_in(pad_in), .sync_in(sync_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .dout_q(dout_q), .dir_q(dir_q), .inen_q(inen_q), .fen_q(fen_q), .fsel_q(fsel_q)
);

// File: tb/sim_gpio_mux_port.sv
module sim_gpio_mux_port;
  localparam int NP = 16;
  localparam int NF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe, sync_in;
  logic [63:0] fn_out = '0;
  logic [63:0] fn_oe = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gpio_mux_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .fn_out(fn_out), .fn_oe(fn_oe),
    .sync_in(sync_in)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [15:0] exp_pad(input logic [63:0] src, input logic [15:0] fen,
                                          input logic [31:0] fsel, input logic [15:0] gpio);
    logic [15:0] r;
    for (int n = 0; n < NP; n++) begin
      int s = (fsel >> (2*n)) & 3;
      r[n] = fen[n] ? src[s*NP + n] : gpio[n];
    end
    return r;
  endfunction

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [15:0] dl, dr, fe;
    logic [31:0] fs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v);
      chk("R1 reset reg", {32'd0, v}, 64'd0);
    end
    chk("R1 reset pad_oe", {48'd0, pad_oe}, 64'd0);
    chk("R1 reset sync_in", {48'd0, sync_in}, 64'd0);

    // R2 whole write and set alias
    wr(4'd0, 32'h0000_A5A5);
    rd(4'd1, v); chk("R2 whole write", {32'd0, v}, 64'hA5A5);
    wr(4'd1, 32'hFFFF_0F00);
    rd(4'd1, v); chk("R2 set alias", {32'd0, v}, 64'hAFA5);
    rd(4'd0, v); chk("R2 data read latch", {32'd0, v}, 64'hAFA5);
    // R3 clear alias
    wr(4'd2, 32'h0000_00A0);
    rd(4'd2, v); chk("R3 clear alias", {32'd0, v}, 64'hAF05);
    dl = 16'hAF05;

    // R4 direction
    wr(4'd3, 32'h0000_1200);
    wr(4'd4, 32'h0000_00FF);
    wr(4'd5, 32'h0000_000F);
    rd(4'd4, v); chk("R4 dirset readback", {32'd0, v}, 64'h12F0);
    rd(4'd3, v); chk("R4 dir readback", {32'd0, v}, 64'h12F0);
    rd(4'd5, v); chk("R4 dirclr readback", {32'd0, v}, 64'h12F0);
    dr = 16'h12F0;

    // R6 GPIO pad drive
    chk("R6 pad_oe", {48'd0, pad_oe}, {48'd0, dr});
    chk("R6 pad_out", {48'd0, pad_out}, {48'd0, dl});

    // R8 synchronizer latency
    @(negedge clk); pad_in = 16'h3C3C;
    @(negedge clk); chk("R8 one edge", {48'd0, sync_in}, 64'd0);
    @(negedge clk); chk("R8 two edges", {48'd0, sync_in}, 64'h3C3C);

    // R5 data read blend, several input-enable masks
    for (int k = 0; k < 4; k++) begin
      logic [15:0] en = 16'hFF00 >> (4*k);
      wr(4'd6, {16'd0, en});
      rd(4'd0, v);
      chk("R5 blend", {32'd0, v}, {48'd0, (16'h3C3C & en) | (dl & ~en)});
    end
    chk("R8 ignores inen", {48'd0, sync_in}, 64'h3C3C);

    // R7 function sweep: every pin, every selector, several data patterns
    for (int rot = 0; rot < NF; rot++) begin
      fs = '0;
      for (int n = 0; n < NP; n++) fs[2*n +: 2] = 2'((n + rot) % NF);
      for (int seed = 1; seed < 5; seed++) begin
        fe = (seed == 4) ? 16'h5A3C : 16'hFFFF;
        wr(4'd7, {16'd0, fe});
        wr(4'd8, fs);
        fn_out = {32'(seed) * 32'h9E37_79B1, 32'(seed) * 32'h7F4A_7C15};
        fn_oe  = {32'(seed) * 32'h85EB_CA6B, 32'(seed) * 32'hC2B2_AE35};
        #1;
        chk("R7 pad_out", {48'd0, pad_out}, {48'd0, exp_pad(fn_out, fe, fs, dl)});
        chk("R7 pad_oe", {48'd0, pad_oe}, {48'd0, exp_pad(fn_oe, fe, fs, dr)});
      end
    end
    rd(4'd8, v); chk("R7 sel readback", {32'd0, v}, {32'd0, fs});

    // R9 unmapped address
    for (int a = 9; a < 16; a++) begin
      wr(4'(a), 32'hFFFF_FFFF);
      rd(4'(a), v); chk("R9 unmapped read", {32'd0, v}, 64'd0);
    end
    rd(4'd1, v); chk("R9 latch unchanged", {32'd0, v}, {48'd0, dl});
    rd(4'd3, v); chk("R9 dir unchanged", {32'd0, v}, {48'd0, dr});
    rd(4'd7, v); chk("R9 fen unchanged", {32'd0, v}, 64'h5A3C);
    rd(4'd8, v); chk("R9 sel unchanged", {32'd0, v}, {32'd0, fs});

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule